// File: doc/BRIEF.md
# Addressed Serial Receiver with Hardware ID Filter

This block receives asynchronous serial frames on a single line. Each bit is sampled at its centre using a fixed 16x oversampling clock taken from a programmable divider. It has two frame formats. In plain mode a frame is a start bit, eight data bits sent least significant bit first, and a stop bit. In addressed mode an extra ID bit follows the data bits. This bit marks the frame as a station-address frame (1) or a payload frame (0).

Software can set a wait-for-ID control bit. It then sleeps through traffic meant for other stations. While that bit is set in addressed mode, payload frames are dropped entirely: the data register is not loaded, no errors are checked and no interrupt is raised. When the next address frame arrives, it is taken in as a normal frame and the wait bit clears itself. Software then reads the address and decides whether to wait again. A receive-full interrupt and an error interrupt report accepted frames.

Top module: `mprx_top`

## Requirements
- R1: After reset, the data register and all four status flags read 0, wait-for-ID reads 0, addressed mode and interrupt enable are off, and both interrupts are low.
- R2: In plain mode, a start / 8 data (LSB first) / stop frame with a high stop bit loads the data register and sets the full flag (st_flags bit 0). With the interrupt enabled, irq_rx is then high.
- R3: A frame whose stop-bit sample is low sets the framing flag (st_flags bit 1). It leaves the data register and the full flag unchanged and raises irq_err when the interrupt is enabled.
- R4: An accepted frame that completes while the full flag is set sets the overrun flag (st_flags bit 2). The data register keeps its old value.
- R5: In addressed mode the frame carries an ID bit after bit 7 and before the stop bit. Every accepted frame copies that bit into the ID flag (st_flags bit 3).
- R6: In addressed mode with wait-for-ID set, a frame with ID bit 0 changes neither the data register nor any status flag, even when its stop bit is low.
- R7: In addressed mode with wait-for-ID set, a frame with ID bit 1 clears wait-for-ID and sets the ID flag. It is otherwise handled as a normal accepted frame.
- R8: While addressed mode and wait-for-ID are both set, irq_rx and irq_err stay low, whatever the flags hold.
- R9: In plain mode, the wait-for-ID bit has no effect: frames are received normally and the bit keeps its written value.
- R10: A low pulse on rxd that is high again at the start bit's midpoint starts no frame.
- R11: A clear strobe clears exactly the flags whose mask bits are 1. A configuration write of 0 clears wait-for-ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial receive line, idles high |
| cfg_we | input | 1 | Strobe: write the three configuration bits below |
| cfg_mproc | input | 1 | Addressed (ID bit) frame mode |
| cfg_id_wait | input | 1 | Wait-for-ID filter enable |
| cfg_irq_en | input | 1 | Receive and error interrupt enable |
| clr_we | input | 1 | Strobe: clear the status flags selected by clr_mask |
| clr_mask | input | 4 | Flag clear mask, same bit positions as st_flags |
| rx_data | output | 8 | Receive data register |
| st_flags | output | 4 | {ID, overrun, framing, full} |
| id_wait | output | 1 | Current wait-for-ID state |
| irq_rx | output | 1 | Receive-full interrupt request |
| irq_err | output | 1 | Receive-error interrupt request |

## Verification
A wrongly decided filter shows up on the first payload frame after the stop-bit midpoint. In that cycle the data register, a flag or an interrupt changes when it should not, or id_wait fails to drop after an address frame. A sampler that is off by one bit or one phase puts shifted data or a wrong framing flag on the ports at the end of the same frame. Every scenario reads the registers one or more bit periods after the frame ends, so each such fault appears within a single frame time.

// File: rtl/mprx_pkg.sv
package mprx_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_IDBIT,
        S_STOP
    } rx_state_e;

    localparam int NFLAGS   = 4;
    localparam int FLG_FULL = 0;
    localparam int FLG_FERR = 1;
    localparam int FLG_OVR  = 2;
    localparam int FLG_ID   = 3;

endpackage

// File: rtl/mprx_bit_sampler.sv
module mprx_bit_sampler
    import mprx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16,
    parameter int DIV    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd,
    input  logic              mproc,
    output logic              frm_done,
    output logic [DATA_W-1:0] frm_data,
    output logic              frm_idbit,
    output logic              frm_stop_ok
);

    localparam int DIVW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int OVSW = $clog2(OVS);
    localparam int BITW = $clog2(DATA_W);
    localparam logic [DIVW-1:0] DIV_LAST = DIVW'(DIV - 1);
    localparam logic [OVSW-1:0] OS_LAST  = OVSW'(OVS - 1);
    localparam logic [OVSW-1:0] OS_MID   = OVSW'(OVS / 2 - 1);
    localparam logic [BITW-1:0] BIT_LAST = BITW'(DATA_W - 1);

    typedef struct packed {
        rx_state_e         st;
        logic [DIVW-1:0]   div;
        logic [OVSW-1:0]   os;
        logic [BITW-1:0]   bidx;
        logic [DATA_W-1:0] sh;
        logic              idb;
        logic [1:0]        sync;
        logic              last;
        logic              done;
        logic              stop_ok;
    } smp_t;

    smp_t q, d;
    logic rx_s;
    logic tick;
    logic os_end;

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        d.sync  = {q.sync[0], rxd};
        rx_s    = q.sync[1];
        d.last  = rx_s;
        tick    = (q.div == DIV_LAST);
        os_end  = tick && (q.os == OS_LAST);
        d.div   = tick ? '0 : q.div + DIVW'(1);
        case (q.st)
            S_IDLE: begin
                if (q.last && !rx_s) begin
                    d.st  = S_START;
                    d.os  = '0;
                    d.div = '0;
                end
            end
            S_START: begin
                if (tick) begin
                    if (q.os == OS_MID) begin
                        d.os   = '0;
                        d.bidx = '0;
                        d.st   = rx_s ? S_IDLE : S_DATA;
                    end else begin
                        d.os = q.os + OVSW'(1);
                    end
                end
            end
            S_DATA: begin
                if (os_end) begin
                    d.os = '0;
                    d.sh = {rx_s, q.sh[DATA_W-1:1]};
                    if (q.bidx == BIT_LAST) begin
                        d.st = mproc ? S_IDBIT : S_STOP;
                    end else begin
                        d.bidx = q.bidx + BITW'(1);
                    end
                end else if (tick) begin
                    d.os = q.os + OVSW'(1);
                end
            end
            S_IDBIT: begin
                if (os_end) begin
                    d.os  = '0;
                    d.idb = rx_s;
                    d.st  = S_STOP;
                end else if (tick) begin
                    d.os = q.os + OVSW'(1);
                end
            end
            S_STOP: begin
                if (os_end) begin
                    d.stop_ok = rx_s;
                    d.done    = 1'b1;
                    d.st      = S_IDLE;
                    if (!mproc) d.idb = 1'b0;
                end else if (tick) begin
                    d.os = q.os + OVSW'(1);
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.st      <= S_IDLE;
            q.sync    <= 2'b11;
            q.last    <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign frm_done    = q.done;
    assign frm_data    = q.sh;
    assign frm_idbit   = q.idb;
    assign frm_stop_ok = q.stop_ok;

    // R2: a completed frame is reported in exactly one cycle
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done |=> !frm_done);

    // R10: leaving the start state without a low midpoint returns to idle, no frame
    p_start_reject_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_START && tick && q.os == OS_MID && rx_s) |=> (q.st == S_IDLE && !frm_done));

endmodule

// File: rtl/mprx_flag_regs.sv
module mprx_flag_regs
    import mprx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_done,
    input  logic [DATA_W-1:0] frm_data,
    input  logic              frm_idbit,
    input  logic              frm_stop_ok,
    input  logic              cfg_we,
    input  logic              cfg_mproc,
    input  logic              cfg_id_wait,
    input  logic              cfg_irq_en,
    input  logic              clr_we,
    input  logic [NFLAGS-1:0] clr_mask,
    output logic              mproc,
    output logic [DATA_W-1:0] rx_data,
    output logic [NFLAGS-1:0] st_flags,
    output logic              id_wait,
    output logic              irq_rx,
    output logic              irq_err
);

    typedef struct packed {
        logic              mproc;
        logic              wait_id;
        logic              irq_en;
        logic [DATA_W-1:0] data;
        logic [NFLAGS-1:0] flags;
    } reg_t;

    reg_t q, d;
    logic filt;
    logic accept;

    always_comb begin
        d      = q;
        filt   = q.mproc && q.wait_id;
        accept = frm_done && !(filt && !frm_idbit);
        if (clr_we) d.flags = q.flags & ~clr_mask;
        if (cfg_we) begin
            d.mproc   = cfg_mproc;
            d.wait_id = cfg_id_wait;
            d.irq_en  = cfg_irq_en;
        end
        if (accept) begin
            if (q.mproc) d.flags[FLG_ID] = frm_idbit;
            if (filt && !cfg_we) d.wait_id = 1'b0;
            if (q.flags[FLG_FULL]) begin
                d.flags[FLG_OVR] = 1'b1;
            end else if (!frm_stop_ok) begin
                d.flags[FLG_FERR] = 1'b1;
            end else begin
                d.data            = frm_data;
                d.flags[FLG_FULL] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mproc    = q.mproc;
    assign rx_data  = q.data;
    assign st_flags = q.flags;
    assign id_wait  = q.wait_id;
    assign irq_rx   = q.irq_en && q.flags[FLG_FULL] && !filt;
    assign irq_err  = q.irq_en && (q.flags[FLG_FERR] || q.flags[FLG_OVR]) && !filt;

    // R6: a payload frame under the filter leaves data and flags untouched
    p_filter_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && q.mproc && q.wait_id && !frm_idbit && !clr_we && !cfg_we)
        |=> ($stable(rx_data) && $stable(st_flags)));

    // R7: an address frame under the filter re-arms normal reception
    p_id_rearms_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && q.mproc && q.wait_id && frm_idbit && !cfg_we && !clr_we)
        |=> (!id_wait && st_flags[FLG_ID]));

    // R4: an accepted frame on a full register flags overrun and keeps the data
    p_ovr_keeps_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && st_flags[FLG_FULL] && !(q.mproc && q.wait_id && !frm_idbit)
         && !clr_we && !cfg_we)
        |=> (st_flags[FLG_OVR] && $stable(rx_data)));

    // R8: no interrupt while waiting for an address frame
    p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mproc && id_wait) |-> (!irq_rx && !irq_err));

endmodule

// File: rtl/mprx_top.sv
module mprx_top
    import mprx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16,
    parameter int DIV    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd,
    input  logic              cfg_we,
    input  logic              cfg_mproc,
    input  logic              cfg_id_wait,
    input  logic              cfg_irq_en,
    input  logic              clr_we,
    input  logic [3:0]        clr_mask,
    output logic [DATA_W-1:0] rx_data,
    output logic [3:0]        st_flags,
    output logic              id_wait,
    output logic              irq_rx,
    output logic              irq_err
);

    logic              mproc;
    logic              frm_done;
    logic [DATA_W-1:0] frm_data;
    logic              frm_idbit;
    logic              frm_stop_ok;

    mprx_bit_sampler #(
        .DATA_W (DATA_W),
        .OVS    (OVS),
        .DIV    (DIV)
    ) sampler_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rxd         (rxd),
        .mproc       (mproc),
        .frm_done    (frm_done),
        .frm_data    (frm_data),
        .frm_idbit   (frm_idbit),
        .frm_stop_ok (frm_stop_ok)
    );

    mprx_flag_regs #(
        .DATA_W (DATA_W)
    ) regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .frm_done    (frm_done),
        .frm_data    (frm_data),
        .frm_idbit   (frm_idbit),
        .frm_stop_ok (frm_stop_ok),
        .cfg_we      (cfg_we),
        .cfg_mproc   (cfg_mproc),
        .cfg_id_wait (cfg_id_wait),
        .cfg_irq_en  (cfg_irq_en),
        .clr_we      (clr_we),
        .clr_mask    (clr_mask),
        .mproc       (mproc),
        .rx_data     (rx_data),
        .st_flags    (st_flags),
        .id_wait     (id_wait),
        .irq_rx      (irq_rx),
        .irq_err     (irq_err)
    );

endmodule

// File: tb/mprx_top_tb_top.sv
module mprx_top_tb_top;

    localparam int BIT = 64;  // OVS 16 x DIV 4 clocks per bit

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       cfg_we = 1'b0, cfg_mproc = 1'b0, cfg_id_wait = 1'b0, cfg_irq_en = 1'b0;
    logic       clr_we = 1'b0;
    logic [3:0] clr_mask = 4'h0;
    logic [7:0] rx_data;
    logic [3:0] st_flags;
    logic       id_wait, irq_rx, irq_err;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    mprx_top dut_i (
        .clk(clk), .rst_n(rst_n), .rxd(rxd),
        .cfg_we(cfg_we), .cfg_mproc(cfg_mproc), .cfg_id_wait(cfg_id_wait),
        .cfg_irq_en(cfg_irq_en), .clr_we(clr_we), .clr_mask(clr_mask),
        .rx_data(rx_data), .st_flags(st_flags), .id_wait(id_wait),
        .irq_rx(irq_rx), .irq_err(irq_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hold_bits(input logic v, input int n);
        rxd = v;
        repeat (n * BIT) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic with_id, input logic idb,
                        input logic stop);
        @(negedge clk);
        hold_bits(1'b0, 1);
        for (int i = 0; i < 8; i++) hold_bits(d[i], 1);
        if (with_id) hold_bits(idb, 1);
        hold_bits(stop, 1);
        hold_bits(1'b1, 2);
    endtask

    task automatic set_cfg(input logic mp, input logic w, input logic ie);
        @(negedge clk);
        cfg_we = 1'b1; cfg_mproc = mp; cfg_id_wait = w; cfg_irq_en = ie;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic clear(input logic [3:0] m);
        @(negedge clk);
        clr_we = 1'b1; clr_mask = m;
        @(negedge clk);
        clr_we = 1'b0; clr_mask = 4'h0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 data", rx_data, 8'h00);
        chk("R1 flags", st_flags, 4'h0);
        chk("R1 id_wait", id_wait, 1'b0);
        chk("R1 irqs", {irq_rx, irq_err}, 2'b00);
    endtask

    task automatic t_plain;
        set_cfg(1'b0, 1'b0, 1'b1);
        send(8'hA5, 1'b0, 1'b0, 1'b1);
        chk("R2 data A5", rx_data, 8'hA5);
        chk("R2 flags", st_flags, 4'h1);
        chk("R2 irq_rx", {irq_rx, irq_err}, 2'b10);
        clear(4'h1);
        chk("R11 full cleared", st_flags, 4'h0);
        chk("R11 irq_rx low", irq_rx, 1'b0);
        send(8'h3C, 1'b0, 1'b0, 1'b1);
        chk("R2 data 3C", rx_data, 8'h3C);
    endtask

    task automatic t_ferr;
        clear(4'hF);
        send(8'h5A, 1'b0, 1'b0, 1'b0);
        chk("R3 data kept", rx_data, 8'h3C);
        chk("R3 flags", st_flags, 4'h2);
        chk("R3 irq_err", {irq_rx, irq_err}, 2'b01);
    endtask

    task automatic t_ovr;
        clear(4'hF);
        send(8'h11, 1'b0, 1'b0, 1'b1);
        send(8'h22, 1'b0, 1'b0, 1'b1);
        chk("R4 data kept", rx_data, 8'h11);
        chk("R4 flags", st_flags, 4'h5);
        chk("R4 irq_err", irq_err, 1'b1);
    endtask

    task automatic t_mp_id;
        clear(4'hF);
        set_cfg(1'b1, 1'b0, 1'b1);
        send(8'h47, 1'b1, 1'b1, 1'b1);
        chk("R5 data 47", rx_data, 8'h47);
        chk("R5 id flag set", st_flags, 4'h9);
        clear(4'hF);
        send(8'h48, 1'b1, 1'b0, 1'b1);
        chk("R5 data 48", rx_data, 8'h48);
        chk("R5 id flag clear", st_flags, 4'h1);
    endtask

    task automatic t_filter;
        // full flag still set from 0x48
        set_cfg(1'b1, 1'b1, 1'b1);
        chk("R8 irqs masked", {irq_rx, irq_err}, 2'b00);
        send(8'h20, 1'b1, 1'b0, 1'b1);
        chk("R6 data kept", rx_data, 8'h48);
        chk("R6 no overrun", st_flags, 4'h1);
        chk("R6 still waiting", id_wait, 1'b1);
        clear(4'hF);
        send(8'h99, 1'b1, 1'b0, 1'b0);
        chk("R6 bad stop ignored", st_flags, 4'h0);
        chk("R6 data still", rx_data, 8'h48);
        chk("R8 irqs quiet", {irq_rx, irq_err}, 2'b00);
    endtask

    task automatic t_rearm;
        send(8'h31, 1'b1, 1'b1, 1'b1);
        chk("R7 wait cleared", id_wait, 1'b0);
        chk("R7 flags", st_flags, 4'h9);
        chk("R7 data", rx_data, 8'h31);
        chk("R7 irq_rx back", irq_rx, 1'b1);
    endtask

    task automatic t_mp_off;
        clear(4'hF);
        set_cfg(1'b0, 1'b1, 1'b1);
        send(8'h77, 1'b0, 1'b0, 1'b1);
        chk("R9 data", rx_data, 8'h77);
        chk("R9 flags", st_flags, 4'h1);
        chk("R9 wait kept", id_wait, 1'b1);
        chk("R9 irq_rx", irq_rx, 1'b1);
    endtask

    task automatic t_glitch;
        clear(4'hF);
        @(negedge clk);
        rxd = 1'b0;
        repeat (12) @(negedge clk);
        hold_bits(1'b1, 12);
        chk("R10 no frame flags", st_flags, 4'h0);
        chk("R10 no frame data", rx_data, 8'h77);
        send(8'h0F, 1'b0, 1'b0, 1'b1);
        chk("R10 recovers", rx_data, 8'h0F);
    endtask

    task automatic t_sw_clear;
        set_cfg(1'b1, 1'b1, 1'b1);
        set_cfg(1'b1, 1'b0, 1'b1);
        chk("R11 wait written 0", id_wait, 1'b0);
        clear(4'h2);
        chk("R11 partial clear", st_flags, 4'h1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_plain();
        t_ferr();
        t_ovr();
        t_mp_id();
        t_filter();
        t_rearm();
        t_mp_off();
        t_glitch();
        t_sw_clear();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule